// File: doc/BRIEF.md
# Time Slot Switch with Pattern-Owned Ports

This block exchanges samples between channels that share one time-multiplexed slot sequence. A free-running counter steps through every channel number, one per clock. On each slot a set of ordered bit-pattern rules on the low bits of the channel number picks which of seven ports owns the slot. That port's incoming sample is stored under the current channel number. The same port is then given the sample that the routing table names for that slot.

The routing table is indexed by destination channel and holds the source channel. To carry channel A's data out on channel B, the host writes A at address B. Host writes go to a shadow copy. The copy in use is refreshed from the shadow at each frame boundary, so a frame never sees a half-changed routing. Sample storage has two pages that swap at the frame boundary. Every route therefore has a fixed delay of one frame, whatever the order of source and destination within the frame.

The current slot number, its owner and whether it is live are all driven out. Port logic outside the block uses them to present input samples in step with the slots.

Top module: `tsi_slot_switch`

## Requirements
- R1: `slotChan` is 0 during reset and in the first cycle after it. It then rises by one each clock and wraps from 2^CHAN_W-1 to 0. One such wrap ends a frame.
- R2: Slot ownership is decided on the low channel bits, with the first matching rule winning. In order, the rules are: ..00010000→port 6, ..0011100→port 3, ..0111000→port 4, ..111100→port 3, ..100000→port 4, ..110100→port 5, ..00100→port 0, ..01100→port 1, ..01000→port 2, ..001→port 0, ..010→port 1, ..101→port 2, ..011→port 3, ..111→port 4. An owned slot drives `slotActive`=1 and `slotPort` as the port number.
- R3: Channel 0 (ten low zero bits) is reserved. It and any slot that matches no rule are idle: `slotActive`=0, no output is raised on the next clock, and no port input is stored. An idle channel used as a source therefore reads as zero.
- R4: For an owned slot, the owner's bit of `portOutValid` is 1 during the clock after the slot, and all other bits are 0. After an idle slot all bits are 0.
- R5: The data the owner receives is the sample that was stored, in the previous frame, at the source channel named by the routing entry for the slot. Port p's samples sit at bits [p*DATA_W +: DATA_W] of `portIn` and `portOut`.
- R6: A host write to the routing entry changes the routing only from the first frame that starts after the write. A write accepted during the last slot of a frame applies to the very next frame. Routing entries read later in the frame of the write are unchanged.
- R7: After reset every routing entry holds its own channel number, and both sample pages read as zero. All outputs are zero during reset.
- R8: At most one bit of `portOutValid` is set. The data field of each port that is not valid is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Routing table write strobe |
| hostAddr | input | CHAN_W | Destination channel to program |
| hostData | input | CHAN_W | Source channel to route to it |
| portIn | input | 7*DATA_W | Incoming sample of each port, sampled for the owner of the current slot |
| portOut | output | 7*DATA_W | Outgoing sample of each port, one clock after its slot |
| portOutValid | output | 7 | One bit per port, set for the clock after its owned slot |
| slotChan | output | CHAN_W | Current slot channel number |
| slotActive | output | 1 | Current slot is owned by a port |
| slotPort | output | 3 | Owner of the current slot |

## Verification
Two events can fall on the same clock edge: a host routing write, and the frame wrap that loads the working routing from the shadow. The bench issues a write during the last slot of a frame and expects it to route data in the following frame, with its reference model applying the write before the frame copy. Within a single slot the block also writes the current page and reads the other one. The bench provokes this with routes whose source comes later in the frame than the destination, and routes from a channel to itself. It judges each result against a one-frame-old sample taken from its own model of both pages.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  localparam int NPORT  = 7;
  localparam int PORT_W = 3;
  localparam int NRULE  = 15;

  // One ownership rule: the channel matches when (chan & care) == match.
  typedef struct packed {
    logic [15:0]       care;
    logic [15:0]       match;
    logic [PORT_W-1:0] port;
    logic              reserved;
  } slot_rule_t;

  // Highest priority first: reserved channel, then long patterns, then short.
  localparam slot_rule_t RULES [NRULE] = '{
    '{16'h03FF, 16'h0000, 3'd0, 1'b1},
    '{16'h00FF, 16'h0010, 3'd6, 1'b0},
    '{16'h007F, 16'h001C, 3'd3, 1'b0},
    '{16'h007F, 16'h0038, 3'd4, 1'b0},
    '{16'h003F, 16'h003C, 3'd3, 1'b0},
    '{16'h003F, 16'h0020, 3'd4, 1'b0},
    '{16'h003F, 16'h0034, 3'd5, 1'b0},
    '{16'h001F, 16'h0004, 3'd0, 1'b0},
    '{16'h001F, 16'h000C, 3'd1, 1'b0},
    '{16'h001F, 16'h0008, 3'd2, 1'b0},
    '{16'h0007, 16'h0001, 3'd0, 1'b0},
    '{16'h0007, 16'h0002, 3'd1, 1'b0},
    '{16'h0007, 16'h0005, 3'd2, 1'b0},
    '{16'h0007, 16'h0003, 3'd3, 1'b0},
    '{16'h0007, 16'h0007, 3'd4, 1'b0}
  };

  // Strobes from the slot control to the datapath.
  typedef struct packed {
    logic              slotLive;
    logic [PORT_W-1:0] owner;
    logic              frameEnd;
    logic              pageSel;
  } ctrl_strobe_t;

endpackage

// File: rtl/tsi_slot_ctrl.sv
module tsi_slot_ctrl
  import tsi_pkg::*;
#(
  parameter int CHAN_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [CHAN_W-1:0] slotChan,
  output ctrl_strobe_t      strobe
);

  logic [CHAN_W-1:0] slotCnt;
  logic              pageSel;
  logic [NRULE-1:0]  ruleHit;
  logic [15:0]       chanWide;
  int                winner;

  assign chanWide = 16'(slotCnt);

  for (genvar g = 0; g < NRULE; g++) begin : g_rule
    assign ruleHit[g] = ((chanWide & RULES[g].care) == RULES[g].match);
  end

  // Lowest index that hits wins; scan downward so it is assigned last.
  always_comb begin
    winner = NRULE;
    for (int g = NRULE - 1; g >= 0; g--) begin
      if (ruleHit[g]) winner = g;
    end
  end

  always_comb begin
    strobe.slotLive = 1'b0;
    strobe.owner    = '0;
    if (winner < NRULE) begin
      strobe.slotLive = !RULES[winner].reserved;
      strobe.owner    = RULES[winner].port;
    end
    strobe.frameEnd = &slotCnt;
    strobe.pageSel  = pageSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= '0;
      pageSel <= 1'b0;
    end else begin
      slotCnt <= slotCnt + 1'b1;
      if (&slotCnt) pageSel <= ~pageSel;
    end
  end

  assign slotChan = slotCnt;

endmodule

// File: rtl/tsi_slot_datapath.sv
module tsi_slot_datapath
  import tsi_pkg::*;
#(
  parameter int CHAN_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CHAN_W-1:0]       slotChan,
  input  ctrl_strobe_t            strobe,
  input  logic                    hostWe,
  input  logic [CHAN_W-1:0]       hostAddr,
  input  logic [CHAN_W-1:0]       hostData,
  input  logic [NPORT*DATA_W-1:0] portIn,
  output logic [NPORT*DATA_W-1:0] portOut,
  output logic [NPORT-1:0]        portOutValid
);

  localparam int NCH = 1 << CHAN_W;

  logic [CHAN_W-1:0] shadowCm [NCH];
  logic [CHAN_W-1:0] activeCm [NCH];
  logic [DATA_W-1:0] page     [2][NCH];

  logic [CHAN_W-1:0] srcChan;
  logic [DATA_W-1:0] rdData;
  logic [DATA_W-1:0] inSample;

  assign srcChan = activeCm[slotChan];
  assign rdData  = page[~strobe.pageSel][srcChan];

  always_comb begin
    inSample = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (strobe.owner == PORT_W'(p)) inSample = portIn[p*DATA_W +: DATA_W];
    end
  end

  // Routing: host writes the shadow; the working copy reloads at frame end,
  // with a same-edge host write merged in last.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NCH; i++) begin
        shadowCm[i] <= CHAN_W'(i);
        activeCm[i] <= CHAN_W'(i);
      end
    end else begin
      if (hostWe) shadowCm[hostAddr] <= hostData;
      if (strobe.frameEnd) begin
        activeCm <= shadowCm;
        if (hostWe) activeCm[hostAddr] <= hostData;
      end
    end
  end

  // Sample pages: the current frame writes one page, the other is read.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NCH; i++) begin
        page[0][i] <= '0;
        page[1][i] <= '0;
      end
    end else if (strobe.slotLive) begin
      page[strobe.pageSel][slotChan] <= inSample;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portOut      <= '0;
      portOutValid <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        portOutValid[p] <= strobe.slotLive && (strobe.owner == PORT_W'(p));
        portOut[p*DATA_W +: DATA_W] <=
          (strobe.slotLive && (strobe.owner == PORT_W'(p))) ? rdData : '0;
      end
    end
  end

endmodule

// File: rtl/tsi_slot_switch.sv
module tsi_slot_switch
  import tsi_pkg::*;
#(
  parameter int CHAN_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hostWe,
  input  logic [CHAN_W-1:0]       hostAddr,
  input  logic [CHAN_W-1:0]       hostData,
  input  logic [NPORT*DATA_W-1:0] portIn,
  output logic [NPORT*DATA_W-1:0] portOut,
  output logic [NPORT-1:0]        portOutValid,
  output logic [CHAN_W-1:0]       slotChan,
  output logic                    slotActive,
  output logic [PORT_W-1:0]       slotPort
);

  ctrl_strobe_t strobe;

  tsi_slot_ctrl #(.CHAN_W(CHAN_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .slotChan (slotChan),
    .strobe   (strobe)
  );

  tsi_slot_datapath #(.CHAN_W(CHAN_W), .DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .slotChan     (slotChan),
    .strobe       (strobe),
    .hostWe       (hostWe),
    .hostAddr     (hostAddr),
    .hostData     (hostData),
    .portIn       (portIn),
    .portOut      (portOut),
    .portOutValid (portOutValid)
  );

  assign slotActive = strobe.slotLive;
  assign slotPort   = strobe.owner;

endmodule

// File: rtl/tsi_slot_checker.sv
module tsi_slot_checker #(
  parameter int CW = 10,
  parameter int NP = 7
) (
  input logic          clk,
  input logic          rstN,
  input logic [CW-1:0] slotChan,
  input logic          slotActive,
  input logic [2:0]    slotPort,
  input logic [NP-1:0] portOutValid
);

  // R1: the slot counter steps by one each clock and wraps.
  a_r1_slot_advance: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> slotChan == CW'($past(slotChan) + 1'b1));

  // R3: the reserved channel is never live.
  a_r3_reserved_idle: assert property (@(posedge clk) disable iff (!rstN)
    (slotChan == '0) |-> !slotActive);

  // R3: an idle slot raises no output on the next clock.
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !slotActive |=> portOutValid == '0);

  // R4: a live slot raises exactly its owner's valid one clock later.
  a_r4_valid_follows_slot: assert property (@(posedge clk) disable iff (!rstN)
    slotActive |=> portOutValid == (NP'(1) << $past(slotPort)));

  // R8: never more than one port valid.
  a_r8_single_valid: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(portOutValid));

endmodule

bind tsi_slot_switch tsi_slot_checker #(.CW(CHAN_W), .NP(tsi_pkg::NPORT)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .slotChan     (slotChan),
  .slotActive   (slotActive),
  .slotPort     (slotPort),
  .portOutValid (portOutValid)
);

// File: tb/tsi_slot_switch_tb.sv
module tsi_slot_switch_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CW  = 10;
  localparam int DW  = 16;
  localparam int NP  = 7;
  localparam int NCH = 1 << CW;
  localparam int NFRAMES = 5;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            hostWe = 1'b0;
  logic [CW-1:0]   hostAddr = '0;
  logic [CW-1:0]   hostData = '0;
  logic [NP*DW-1:0] portIn = '0;
  logic [NP*DW-1:0] portOut;
  logic [NP-1:0]   portOutValid;
  logic [CW-1:0]   slotChan;
  logic            slotActive;
  logic [2:0]      slotPort;

  int testsRun = 0;
  int testsFailed = 0;

  typedef struct {
    logic [NP-1:0]    vld;
    logic [NP*DW-1:0] dat;
    string            tagV;
    string            tagD;
  } exp_t;

  exp_t expQ[$];

  logic [CW-1:0] refShadow [NCH];
  logic [CW-1:0] refActive [NCH];
  logic [DW-1:0] refPage   [2][NCH];
  bit            refSel;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsi_slot_switch #(.CHAN_W(CW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostData(hostData), .portIn(portIn), .portOut(portOut),
    .portOutValid(portOutValid), .slotChan(slotChan),
    .slotActive(slotActive), .slotPort(slotPort)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // R2/R3 owner table: -1 for reserved or unmatched.
  function automatic int ownerOf(logic [CW-1:0] ch);
    casez (ch)
      10'b0000000000: return -1;
      10'b??00010000: return 6;
      10'b???0011100: return 3;
      10'b???0111000: return 4;
      10'b????111100: return 3;
      10'b????100000: return 4;
      10'b????110100: return 5;
      10'b?????00100: return 0;
      10'b?????01100: return 1;
      10'b?????01000: return 2;
      10'b???????001: return 0;
      10'b???????010: return 1;
      10'b???????101: return 2;
      10'b???????011: return 3;
      10'b???????111: return 4;
      default:        return -1;
    endcase
  endfunction

  function automatic logic [DW-1:0] gen(int f, int c, int p);
    return DW'((f + 1) * 4096 + p * 613 + c + 1);
  endfunction

  // Monitor: pops one expectation per clock, after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        chk(e.tagV, "valid vector", 32'(portOutValid), 32'(e.vld));
        for (int p = 0; p < NP; p++) begin
          chk(e.vld[p] ? e.tagD : "R8", $sformatf("data port %0d", p),
              32'(portOut[p*DW +: DW]), 32'(e.dat[p*DW +: DW]));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      refShadow[i] = CW'(i);
      refActive[i] = CW'(i);
      refPage[0][i] = '0;
      refPage[1][i] = '0;
    end
    refSel = 1'b0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7", "slotChan in reset", 32'(slotChan), 32'd0);
    chk("R7", "valid in reset", 32'(portOutValid), 32'd0);
    chk("R7", "data in reset", 32'(portOut[DW-1:0]), 32'd0);
    rstN = 1'b1;

    for (int f = 0; f < NFRAMES; f++) begin
      for (int c = 0; c < NCH; c++) begin
        int   own;
        exp_t e;
        own = ownerOf(CW'(c));

        chk("R1", "slot number", 32'(slotChan), 32'(c));
        chk(own < 0 ? "R3" : "R2", "slot live", 32'(slotActive), 32'(own >= 0));
        if (own >= 0) chk("R2", "slot owner", 32'(slotPort), 32'(own));

        for (int p = 0; p < NP; p++) portIn[p*DW +: DW] = gen(f, c, p);

        // Host routing writes (R6), including one on the last slot of a frame.
        hostWe = 1'b0;
        if (f == 1 && c == 5)    begin hostWe = 1'b1; hostAddr = 10'h00A; hostData = 10'h014; end
        if (f == 1 && c == 100)  begin hostWe = 1'b1; hostAddr = 10'h001; hostData = 10'h03C; end
        if (f == 2 && c == 2)    begin hostWe = 1'b1; hostAddr = 10'h00C; hostData = 10'h001; end
        if (f == 2 && c == 1023) begin hostWe = 1'b1; hostAddr = 10'h004; hostData = 10'h3FF; end
        if (f == 3 && c == 512)  begin hostWe = 1'b1; hostAddr = 10'h010; hostData = 10'h007; end

        e.vld = '0;
        e.dat = '0;
        e.tagV = "R3";
        e.tagD = "R5";
        if (own >= 0) begin
          logic [CW-1:0] src;
          src = refActive[c];
          e.vld[own] = 1'b1;
          e.dat[own*DW +: DW] = refPage[~refSel][src];
          e.tagV = "R4";
          if (f == 0)                e.tagD = "R7";
          else if (ownerOf(src) < 0) e.tagD = "R3";
          else if (src != CW'(c))    e.tagD = "R6";
          else                       e.tagD = "R5";
        end
        expQ.push_back(e);

        if (own >= 0) refPage[refSel][c] = gen(f, c, own);
        if (hostWe) refShadow[hostAddr] = hostData;
        if (c == NCH - 1) begin
          for (int i = 0; i < NCH; i++) refActive[i] = refShadow[i];
          refSel = ~refSel;
        end

        @(negedge clk);
      end
    end

    hostWe = 1'b0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule